// File: doc/BRIEF.md
# Hamming (11,7) Single-Error Codec

This block protects a 7-bit word with four even-parity check bits, forming an 11-bit codeword. Codeword positions are numbered 1 to 11. Position p is carried on frame bit p-1. The check bits occupy the positions whose index is a power of two. The encode path turns a data word into a codeword. The decode path takes a received codeword and computes a 4-bit syndrome. It then returns the recovered data word together with status flags.

The decoder does not blindly invert the bit that the syndrome points at. A syndrome that points at a check position means only a check bit was hit, so the data passes through unchanged. A syndrome that points at a data position inverts that data bit. A syndrome of 12 to 15 names a position that does not exist, so it is reported as uncorrectable. Both paths are combinational and end in one shared register stage, which a single valid strobe loads.

Top module: `hamm11_codec`

## Requirements
- R1: Check bits sit at positions 1, 2, 4 and 8 (frame bits 0, 1, 3, 7). Data bit 6 goes to position 11, bit 5 to 10, bit 4 to 9, bit 3 to 7, bit 2 to 6, bit 1 to 5 and bit 0 to 3.
- R2: Check bit 2^k is the even parity of all positions whose index has bit k set, so data 1001101 encodes to frame 10011100101 (position 11 first).
- R3: Syndrome bit k is the parity of the received positions whose index has bit k set. A syndrome of zero raises no flag and returns the data bits exactly as received.
- R4: A syndrome of 3, 5, 6, 7, 9, 10 or 11 inverts the data bit at that position and raises the corrected flag.
- R5: A syndrome of 1, 2, 4 or 8 leaves the data as received and raises the parity-hit flag.
- R6: A syndrome of 12 to 15 raises the uncorrectable flag and returns the data bits exactly as received.
- R7: Frame 10011100101 with position 6 inverted yields syndrome 0110 and data 1001101.
- R8: All outputs load on the rising clock edge that samples in_valid high. out_valid is high in the cycle after each such edge and low after an edge that samples in_valid low.
- R9: While in_valid is low, the data, frame, syndrome and flag outputs hold their values.
- R10: An active-low reset, applied asynchronously, clears every output to zero.
- R11: At most one of the three status flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load strobe for both paths |
| enc_data | input | 7 | Word to encode |
| dec_frame | input | 11 | Received codeword, bit p-1 is position p |
| out_valid | output | 1 | Outputs were loaded on the last edge |
| out_frame | output | 11 | Encoded codeword |
| out_data | output | 7 | Recovered data word |
| out_syndrome | output | 4 | Syndrome of the received codeword |
| out_corrected | output | 1 | A data bit was inverted |
| out_parity_hit | output | 1 | Syndrome named a check position |
| out_uncorrectable | output | 1 | Syndrome beyond position 11 |

## Verification
A wrong coverage mask in the encode path or in the syndrome path appears one edge after a strobe. It shows either as a codeword that differs from an independently built one, or as a nonzero syndrome on a clean frame. A fault in the syndrome classification appears in the same cycle as a wrong flag or an extra inverted data bit. Each class is driven at least once: clean frames, single hits on data positions, single hits on check positions, and paired hits that reach syndromes 12 and 15. A stage that loads on the wrong strobe shows as a changed output during the hold window, or as a mistimed out_valid in back-to-back transfers.

// File: rtl/hamm11_pkg.sv
`timescale 1ns/1ps
package hamm11_pkg;
  localparam int PAR_W   = 4;
  localparam int DATA_W  = 7;
  localparam int FRAME_W = DATA_W + PAR_W;

  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [PAR_W-1:0]   syn_t;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_DATA   = 2'd1,
    CLS_PARITY = 2'd2,
    CLS_BEYOND = 2'd3
  } syn_class_e;

  // Position index with a single 1: carries a check bit
  function automatic bit is_check_pos(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Positions whose index has bit k set
  function automatic frame_t cover_mask(int k);
    frame_t m;
    m = '0;
    for (int p = 1; p <= FRAME_W; p++)
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction

  // Data bits fill non-check positions, LSB at the lowest
  function automatic frame_t scatter(data_t d);
    frame_t f;
    int     j;
    f = '0;
    j = 0;
    for (int p = 1; p <= FRAME_W; p++) begin
      if (!is_check_pos(p)) begin
        f[p-1] = d[j];
        j++;
      end
    end
    return f;
  endfunction

  function automatic data_t gather(frame_t f);
    data_t d;
    int    j;
    d = '0;
    j = 0;
    for (int p = 1; p <= FRAME_W; p++) begin
      if (!is_check_pos(p)) begin
        d[j] = f[p-1];
        j++;
      end
    end
    return d;
  endfunction

  // Syndrome policy
  function automatic syn_class_e classify(syn_t s);
    if (s == '0) return CLS_CLEAN;
    if ($countones(s) == 1) return CLS_PARITY;
    if (int'(s) > FRAME_W) return CLS_BEYOND;
    return CLS_DATA;
  endfunction
endpackage

// File: rtl/hamm11_encoder.sv
`timescale 1ns/1ps
module hamm11_encoder
  import hamm11_pkg::*;
(
  input  data_t  data,
  output frame_t frame
);
  frame_t placed;
  syn_t   par;

  assign placed = scatter(data);

  for (genvar k = 0; k < PAR_W; k++) begin : g_par
    localparam frame_t MASK = cover_mask(k);
    assign par[k] = ^(placed & MASK);
  end

  always_comb begin
    frame = placed;
    for (int k = 0; k < PAR_W; k++)
      frame[(1 << k) - 1] = par[k];
  end
endmodule

// File: rtl/hamm11_syndrome.sv
`timescale 1ns/1ps
module hamm11_syndrome
  import hamm11_pkg::*;
(
  input  frame_t     rx_frame,
  output syn_t       syn,
  output syn_class_e cls
);
  for (genvar k = 0; k < PAR_W; k++) begin : g_chk
    localparam frame_t MASK = cover_mask(k);
    assign syn[k] = ^(rx_frame & MASK);
  end

  assign cls = classify(syn);
endmodule

// File: rtl/hamm11_corrector.sv
`timescale 1ns/1ps
module hamm11_corrector
  import hamm11_pkg::*;
(
  input  frame_t     rx_frame,
  input  syn_t       syn,
  input  syn_class_e cls,
  output data_t      fixed
);
  frame_t flip;

  for (genvar p = 1; p <= FRAME_W; p++) begin : g_flip
    assign flip[p-1] = (cls == CLS_DATA) && (syn == syn_t'(p));
  end

  assign fixed = gather(rx_frame ^ flip);
endmodule

// File: rtl/hamm11_codec.sv
`timescale 1ns/1ps
module hamm11_codec
  import hamm11_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    enc_data,
  input  logic [FRAME_W-1:0]   dec_frame,
  output logic                 out_valid,
  output logic [FRAME_W-1:0]   out_frame,
  output logic [DATA_W-1:0]    out_data,
  output logic [PAR_W-1:0]     out_syndrome,
  output logic                 out_corrected,
  output logic                 out_parity_hit,
  output logic                 out_uncorrectable
);
  frame_t     enc_w;
  syn_t       syn_w;
  syn_class_e cls_w;
  data_t      fix_w;
  logic       hit_data_w;
  logic       hit_par_w;
  logic       hit_over_w;

  hamm11_encoder u_enc (
    .data  (enc_data),
    .frame (enc_w)
  );

  hamm11_syndrome u_syn (
    .rx_frame (dec_frame),
    .syn      (syn_w),
    .cls      (cls_w)
  );

  hamm11_corrector u_fix (
    .rx_frame (dec_frame),
    .syn      (syn_w),
    .cls      (cls_w),
    .fixed    (fix_w)
  );

  assign hit_data_w = (cls_w == CLS_DATA);
  assign hit_par_w  = (cls_w == CLS_PARITY);
  assign hit_over_w = (cls_w == CLS_BEYOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid         <= 1'b0;
      out_frame         <= '0;
      out_data          <= '0;
      out_syndrome      <= '0;
      out_corrected     <= 1'b0;
      out_parity_hit    <= 1'b0;
      out_uncorrectable <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_frame         <= enc_w;
        out_data          <= fix_w;
        out_syndrome      <= syn_w;
        out_corrected     <= hit_data_w;
        out_parity_hit    <= hit_par_w;
        out_uncorrectable <= hit_over_w;
      end
    end
  end
endmodule

// File: rtl/hamm11_checker.sv
`timescale 1ns/1ps
module hamm11_checker
  import hamm11_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   in_valid,
  input frame_t dec_frame,
  input logic   hit_data_w,
  input logic   hit_par_w,
  input logic   hit_over_w,
  input logic   out_valid,
  input frame_t out_frame,
  input data_t  out_data,
  input syn_t   out_syndrome,
  input logic   out_corrected,
  input logic   out_parity_hit,
  input logic   out_uncorrectable
);
  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_corrected, out_parity_hit, out_uncorrectable}));

  p_class_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_data_w, hit_par_w, hit_over_w}));

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_frame) && $stable(out_syndrome)
                   && $stable(out_corrected) && $stable(out_parity_hit)
                   && $stable(out_uncorrectable)));

  p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_syndrome == '0) |-> !(out_corrected || out_parity_hit || out_uncorrectable));

  p_data_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit_data_w) |=> ($countones(out_data ^ gather($past(dec_frame))) == 1));

  p_parity_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_parity_hit |-> ($countones(out_syndrome) == 1));

  p_beyond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_uncorrectable |-> (int'(out_syndrome) > FRAME_W));

  p_beyond_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit_over_w) |=> (out_data == gather($past(dec_frame))));
endmodule

bind hamm11_codec hamm11_checker u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .in_valid          (in_valid),
  .dec_frame         (dec_frame),
  .hit_data_w        (hit_data_w),
  .hit_par_w         (hit_par_w),
  .hit_over_w        (hit_over_w),
  .out_valid         (out_valid),
  .out_frame         (out_frame),
  .out_data          (out_data),
  .out_syndrome      (out_syndrome),
  .out_corrected     (out_corrected),
  .out_parity_hit    (out_parity_hit),
  .out_uncorrectable (out_uncorrectable)
);

// File: tb/tb_hamm11_codec.sv
`timescale 1ns/1ps
module tb_hamm11_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [6:0]  enc_data = '0;
  logic [10:0] dec_frame = '0;
  logic        out_valid;
  logic [10:0] out_frame;
  logic [6:0]  out_data;
  logic [3:0]  out_syndrome;
  logic        out_corrected;
  logic        out_parity_hit;
  logic        out_uncorrectable;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  hamm11_codec dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_valid          (in_valid),
    .enc_data          (enc_data),
    .dec_frame         (dec_frame),
    .out_valid         (out_valid),
    .out_frame         (out_frame),
    .out_data          (out_data),
    .out_syndrome      (out_syndrome),
    .out_corrected     (out_corrected),
    .out_parity_hit    (out_parity_hit),
    .out_uncorrectable (out_uncorrectable)
  );

  // Bench encoder written as explicit parity equations
  function automatic logic [10:0] b_enc(logic [6:0] d);
    logic c1, c2, c4, c8;
    c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c4 = d[1] ^ d[2] ^ d[3];
    c8 = d[4] ^ d[5] ^ d[6];
    return {d[6], d[5], d[4], c8, d[3], d[2], d[1], c4, d[0], c2, c1};
  endfunction

  function automatic logic [6:0] b_ext(logic [10:0] f);
    return {f[10], f[9], f[8], f[6], f[5], f[4], f[2]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {data[6:0], error mask[10:0], syndrome[3:0], flags {unc,par,corr}}
  localparam int NVEC = 13;
  localparam logic [24:0] VEC [NVEC] = '{
    {7'h4D, 11'h000, 4'd0,  3'b000},  // R2 R3 clean example
    {7'h4D, 11'h020, 4'd6,  3'b001},  // R7 position 6
    {7'h00, 11'h004, 4'd3,  3'b001},  // R4 position 3
    {7'h7F, 11'h400, 4'd11, 3'b001},  // R4 position 11
    {7'h01, 11'h100, 4'd9,  3'b001},  // R4 position 9
    {7'h5A, 11'h200, 4'd10, 3'b001},  // R4 position 10
    {7'h2A, 11'h001, 4'd1,  3'b010},  // R5 position 1
    {7'h7F, 11'h002, 4'd2,  3'b010},  // R5 position 2
    {7'h55, 11'h080, 4'd8,  3'b010},  // R5 position 8
    {7'h13, 11'h088, 4'd12, 3'b100},  // R6 positions 4+8
    {7'h66, 11'h210, 4'd15, 3'b100},  // R6 positions 5+10
    {7'h39, 11'h440, 4'd12, 3'b100},  // R6 positions 7+11
    {7'h3C, 11'h000, 4'd0,  3'b000}   // R3 clean
  };

  logic [6:0]  v_d;
  logic [10:0] v_rx;
  logic [3:0]  v_syn;
  logic [2:0]  v_fl;
  logic [6:0]  v_exp;

  task automatic load_vec(int i);
    v_d   = VEC[i][24:18];
    v_rx  = b_enc(v_d) ^ VEC[i][17:7];
    v_syn = VEC[i][6:3];
    v_fl  = VEC[i][2:0];
    if (v_fl[0]) v_exp = b_ext(v_rx ^ (11'b1 << (v_syn - 4'd1)));
    else         v_exp = b_ext(v_rx);
  endtask

  task automatic check_outputs(string tag);
    chk(tag, "R1 R2 frame", out_frame, b_enc(v_d));
    chk(tag, "R3 syndrome", out_syndrome, v_syn);
    chk(tag, "R4 R5 R6 data", out_data, v_exp);
    chk(tag, "R11 flags", {out_uncorrectable, out_parity_hit, out_corrected}, v_fl);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [10:0] hold_frame;
    logic [6:0]  hold_data;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs cleared under reset
    chk("R10", "valid", out_valid, 0);
    chk("R10", "frame", out_frame, 0);
    chk("R10", "data", out_data, 0);
    chk("R10", "flags", {out_syndrome, out_corrected, out_parity_hit, out_uncorrectable}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: literal example codeword
    chk("R2", "example encoding", b_enc(7'b1001101), 11'b10011100101);

    for (int i = 0; i < NVEC; i++) begin
      load_vec(i);
      enc_data  = v_d;
      dec_frame = v_rx;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8", "out_valid after strobe", out_valid, 1);
      check_outputs($sformatf("vec%0d", i));
      @(negedge clk);
      chk("R8", "out_valid idle", out_valid, 0);
    end

    // R7: explicit example values
    enc_data  = 7'b1001101;
    dec_frame = 11'b10011100101 ^ 11'b00000100000;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "syndrome", out_syndrome, 4'b0110);
    chk("R7", "data", out_data, 7'b1001101);

    // R8: back-to-back strobes
    load_vec(3);
    enc_data = v_d; dec_frame = v_rx; in_valid = 1'b1;
    @(negedge clk);
    chk("R8", "b2b first valid", out_valid, 1);
    check_outputs("b2b first");
    load_vec(10);
    enc_data = v_d; dec_frame = v_rx;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "b2b second valid", out_valid, 1);
    check_outputs("b2b second");

    // R9: inputs change without strobe, outputs hold
    hold_frame = out_frame;
    hold_data  = out_data;
    enc_data   = 7'h2B;
    dec_frame  = 11'h7FF;
    repeat (2) @(negedge clk);
    chk("R9", "frame held", out_frame, hold_frame);
    chk("R9", "data held", out_data, hold_data);
    chk("R9", "syndrome held", out_syndrome, 4'd15);
    chk("R9", "valid low", out_valid, 0);

    // R10: asynchronous reset mid-run
    load_vec(5);
    enc_data = v_d; dec_frame = v_rx; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R10", "async frame", out_frame, 0);
    chk("R10", "async data", out_data, 0);
    chk("R10", "async valid", out_valid, 0);
    chk("R10", "async flags", {out_corrected, out_parity_hit, out_uncorrectable}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule